// File: doc/BRIEF.md
# Multi-Line Tagged Receive Silo

This block gathers incoming characters from up to sixteen serial line receivers into one shared first-in first-out store. Each stored entry records the character, the number of the line that delivered it, and three error indications: parity, framing (a received break) and overrun. The host reads a single 16-bit word. The top bit of that word is set while a character is available, so software can keep reading for as long as the word is negative. Each read removes one entry.

Each line has a one-character holding stage. When several lines deliver in the same cycle, a fixed-priority arbiter moves one held character per cycle into the store, lowest line number first. A programmable alarm level sets how many entries must be waiting before a receive request is raised. That request is gated by an enable to form the interrupt. An alarm level of zero raises the request as soon as any character is waiting.

Top module: `rx_silo`

## Requirements
- R1: While the store is empty the read word is 16'h0000, so bit 15 is 0. While at least one entry is waiting, bit 15 is 1.
- R2: For a valid entry, bits [7:0] hold the character and bits [11:8] hold the source line number (0 to 15).
- R3: Bit 12 is set when the character had a parity error, and bit 13 is set when it had a framing error.
- R4: Asserting `rd_pop` while bit 15 is 1 removes exactly one entry at the next clock edge. Entries leave in the order they were stored.
- R5: Characters presented by several lines in the same cycle are stored one per cycle, in ascending line-number order.
- R6: The store holds `DEPTH` (64) entries. A character that arrives while the store is full and no pop is in progress is discarded. The next entry written afterwards has bit 14 (overrun) set.
- R7: If a line delivers a new character before its previous one has been moved into the store, the older one is lost. The newer one is stored with bit 14 set.
- R8: `rx_pend` is 1 when the number of stored entries is nonzero and at least the alarm level. With an alarm level of 0, any stored entry raises it. `alarm_we` loads `alarm_val` as the new level at the clock edge.
- R9: `rx_irq` equals `rx_pend` AND `rx_ie`.
- R10: After reset the store is empty, `rx_pend` and `rx_irq` are 0, and the alarm level is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_valid | input | LINES | Per-line strobe, one cycle per received character |
| ln_char | input | 8*LINES | Per-line character, line n in bits [8n+7:8n] |
| ln_perr | input | LINES | Per-line parity error for the presented character |
| ln_ferr | input | LINES | Per-line framing error (break) for the presented character |
| rd_pop | input | 1 | Remove the head entry at this edge |
| alarm_we | input | 1 | Load a new alarm level |
| alarm_val | input | CW | Alarm level to load |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_word | output | 16 | Head entry word: valid, overrun, framing, parity, line, character |
| rx_pend | output | 1 | Fill level has reached the alarm |
| rx_irq | output | 1 | Enabled receive interrupt |

## Verification
The bench fills the store to exactly 64 entries and then offers one more character. A design with an off-by-one full flag would keep that character or lose the one before it, and a design that forgets the lost character would write the next entry without its overrun bit. Lines 1, 3 and 7 deliver in the same cycle; a reversed or rotating arbiter would return them in the wrong order. A line re-delivers while it is still waiting behind lower-numbered lines; a design that does not catch this would either store both characters or store the newer one without the overrun bit. The alarm is checked at its reset level (the request must stay low at 15 entries and rise at 16), at a small level, and at zero. A comparison off by one would move the point where the request rises.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    localparam int TAG_W  = 4;
    localparam int CHAR_W = 8;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [TAG_W-1:0]  line;
        logic [CHAR_W-1:0] ch;
    } silo_entry_t;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } held_char_t;

    function automatic logic [WORD_W-1:0] pack_word(logic present, silo_entry_t e);
        return present ? {1'b1, e} : '0;
    endfunction

endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
    import rx_silo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [CHAR_W-1:0] in_ch,
    input  logic              in_pe,
    input  logic              in_fe,
    input  logic              take,
    output logic              held_v,
    output held_char_t        held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held   <= '0;
        end else if (in_v) begin
            held_v    <= 1'b1;
            held.ch   <= in_ch;
            held.perr <= in_pe;
            held.ferr <= in_fe;
            held.ovr  <= held_v && !take;
        end else if (take) begin
            held_v <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_prio_arb.sv
module rx_prio_arb #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  silo_entry_t din,
    input  logic        pop,
    output silo_entry_t dout,
    output logic [CW-1:0] fill,
    output logic        full,
    output logic        empty
);

    silo_entry_t   mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      fill <= fill + 1'b1;
            else if (pop && !push) fill <= fill - 1'b1;
        end
    end

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int LINES     = 16,
    parameter int DEPTH     = 64,
    parameter int ALARM_RST = 16,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINES-1:0]        ln_valid,
    input  logic [CHAR_W*LINES-1:0] ln_char,
    input  logic [LINES-1:0]        ln_perr,
    input  logic [LINES-1:0]        ln_ferr,
    input  logic                    rd_pop,
    input  logic                    alarm_we,
    input  logic [CW-1:0]           alarm_val,
    input  logic                    rx_ie,
    output logic [WORD_W-1:0]       rd_word,
    output logic                    rx_pend,
    output logic                    rx_irq
);

    logic [LINES-1:0] held_v;
    held_char_t       held [LINES];
    logic [LINES-1:0] grant;
    logic [TAG_W-1:0] win;
    logic             any_held;
    logic             full, empty, push, pop, accept, drop_flag;
    logic [CW-1:0]    fill;
    logic [CW-1:0]    alarm;
    silo_entry_t      new_e, head_e;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        rx_line_hold u_hold (
            .clk    (clk),
            .rst    (rst),
            .in_v   (ln_valid[g]),
            .in_ch  (ln_char[g*CHAR_W +: CHAR_W]),
            .in_pe  (ln_perr[g]),
            .in_fe  (ln_ferr[g]),
            .take   (grant[g]),
            .held_v (held_v[g]),
            .held   (held[g])
        );
    end

    rx_prio_arb #(.N(LINES), .IW(TAG_W)) u_arb (
        .req (held_v),
        .gnt (grant),
        .idx (win),
        .any (any_held)
    );

    assign pop    = rd_pop && !empty;
    assign accept = !full || pop;
    assign push   = any_held && accept;

    always_comb begin
        new_e.ch   = held[win].ch;
        new_e.perr = held[win].perr;
        new_e.ferr = held[win].ferr;
        new_e.ovr  = held[win].ovr || drop_flag;
        new_e.line = win;
    end

    always_ff @(posedge clk) begin
        if (rst)                      drop_flag <= 1'b0;
        else if (any_held && !accept) drop_flag <= 1'b1;
        else if (push)                drop_flag <= 1'b0;
    end

    rx_silo_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (new_e),
        .pop   (pop),
        .dout  (head_e),
        .fill  (fill),
        .full  (full),
        .empty (empty)
    );

    always_ff @(posedge clk) begin
        if (rst)           alarm <= CW'(ALARM_RST);
        else if (alarm_we) alarm <= alarm_val;
    end

    assign rd_word = pack_word(!empty, head_e);
    assign rx_pend = !empty && (fill >= alarm);
    assign rx_irq  = rx_pend && rx_ie;

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
    parameter int LINES = 16,
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      rd_word,
    input logic             rd_pop,
    input logic             rx_ie,
    input logic             rx_pend,
    input logic             rx_irq,
    input logic [CW-1:0]    fill,
    input logic [CW-1:0]    alarm,
    input logic             push,
    input logic [LINES-1:0] grant
);

    p_empty_word_r1: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> (rd_word == 16'h0000));

    p_pop_one_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && rd_word[15] && !push) |=> (fill == $past(fill) - 1'b1));

    p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    p_alarm_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (alarm == '0 && fill != '0) |-> rx_pend);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_ie && rx_pend));

endmodule

bind rx_silo rx_silo_chk #(.LINES(LINES), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_word (rd_word),
    .rd_pop  (rd_pop),
    .rx_ie   (rx_ie),
    .rx_pend (rx_pend),
    .rx_irq  (rx_irq),
    .fill    (fill),
    .alarm   (alarm),
    .push    (push),
    .grant   (grant)
);

// File: tb/sim_rx_silo.sv
`timescale 1ns/1ps
module sim_rx_silo;

    localparam int CLK_PERIOD = 10;
    localparam int LINES = 16;
    localparam int CW    = 7;

    // vector fields: {line[3:0], char[7:0], perr, ferr}
    localparam logic [13:0] VEC [8] = '{
        {4'd0,  8'h41, 1'b0, 1'b0},
        {4'd15, 8'hFF, 1'b0, 1'b0},
        {4'd9,  8'h00, 1'b1, 1'b0},
        {4'd4,  8'h5A, 1'b0, 1'b1},
        {4'd12, 8'hA5, 1'b1, 1'b1},
        {4'd1,  8'h7F, 1'b0, 1'b0},
        {4'd6,  8'h80, 1'b1, 1'b0},
        {4'd10, 8'h3C, 1'b0, 1'b1}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [LINES-1:0]    ln_valid = '0;
    logic [8*LINES-1:0]  ln_char = '0;
    logic [LINES-1:0]    ln_perr = '0;
    logic [LINES-1:0]    ln_ferr = '0;
    logic                rd_pop = 1'b0;
    logic                alarm_we = 1'b0;
    logic [CW-1:0]       alarm_val = '0;
    logic                rx_ie = 1'b0;
    logic [15:0]         rd_word;
    logic                rx_pend, rx_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_silo u0 (
        .clk(clk), .rst(rst), .ln_valid(ln_valid), .ln_char(ln_char),
        .ln_perr(ln_perr), .ln_ferr(ln_ferr), .rd_pop(rd_pop),
        .alarm_we(alarm_we), .alarm_val(alarm_val), .rx_ie(rx_ie),
        .rd_word(rd_word), .rx_pend(rx_pend), .rx_irq(rx_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(int line, logic [7:0] ch, logic pe, logic fe);
        ln_valid[line]          = 1'b1;
        ln_char[line*8 +: 8]    = ch;
        ln_perr[line]           = pe;
        ln_ferr[line]           = fe;
        tick();
        ln_valid = '0;
        ln_perr  = '0;
        ln_ferr  = '0;
        tick();
    endtask

    task automatic pop_check(string req, logic [15:0] exp);
        check(req, rd_word, exp);
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic set_alarm(logic [CW-1:0] v);
        alarm_val = v;
        alarm_we  = 1'b1;
        tick();
        alarm_we  = 1'b0;
    endtask

    function automatic logic [15:0] w(logic ov, logic fe, logic pe, int line, logic [7:0] ch);
        return {1'b1, ov, fe, pe, 4'(line), ch};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();

        // R10 / R1: reset state
        check("R10 word", rd_word, 16'h0000);
        check("R10 pend", {15'b0, rx_pend}, 16'h0000);
        check("R10 irq", {15'b0, rx_irq}, 16'h0000);

        // R2 R3 R4: vector table, all stored then read in order
        for (int i = 0; i < 8; i++)
            send(int'(VEC[i][13:10]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        for (int i = 0; i < 8; i++)
            pop_check("R2 R3 R4 table", w(1'b0, VEC[i][0], VEC[i][1],
                      int'(VEC[i][13:10]), VEC[i][9:2]));
        check("R1 empty after drain", rd_word, 16'h0000);

        // R5: simultaneous lines 7, 1, 3
        ln_valid = '0;
        ln_valid[7] = 1'b1; ln_char[7*8 +: 8] = 8'h77;
        ln_valid[1] = 1'b1; ln_char[1*8 +: 8] = 8'h11;
        ln_valid[3] = 1'b1; ln_char[3*8 +: 8] = 8'h33;
        tick();
        ln_valid = '0;
        tick(); tick(); tick();
        pop_check("R5 first", w(1'b0, 1'b0, 1'b0, 1, 8'h11));
        pop_check("R5 second", w(1'b0, 1'b0, 1'b0, 3, 8'h33));
        pop_check("R5 third", w(1'b0, 1'b0, 1'b0, 7, 8'h77));

        // R7: line 3 re-delivers while still waiting
        for (int l = 0; l < 4; l++) begin
            ln_valid[l] = 1'b1;
            ln_char[l*8 +: 8] = 8'(8'h10 + l);
        end
        tick();
        ln_valid = '0;
        ln_valid[3] = 1'b1; ln_char[3*8 +: 8] = 8'h33;
        tick();
        ln_valid = '0;
        tick(); tick(); tick();
        pop_check("R7 line0", w(1'b0, 1'b0, 1'b0, 0, 8'h10));
        pop_check("R7 line1", w(1'b0, 1'b0, 1'b0, 1, 8'h11));
        pop_check("R7 line2", w(1'b0, 1'b0, 1'b0, 2, 8'h12));
        pop_check("R7 line3 overrun", w(1'b1, 1'b0, 1'b0, 3, 8'h33));
        check("R7 empty", rd_word, 16'h0000);

        // R8 R10: reset alarm level is 16
        for (int i = 0; i < 15; i++) send(2, 8'(i), 1'b0, 1'b0);
        check("R8 R10 pend at 15", {15'b0, rx_pend}, 16'h0000);
        send(2, 8'd15, 1'b0, 1'b0);
        check("R8 R10 pend at 16", {15'b0, rx_pend}, 16'h0001);
        check("R9 irq disabled", {15'b0, rx_irq}, 16'h0000);
        rx_ie = 1'b1; #1;
        check("R9 irq enabled", {15'b0, rx_irq}, 16'h0001);
        rx_ie = 1'b0;
        for (int i = 0; i < 16; i++)
            pop_check("R4 drain", w(1'b0, 1'b0, 1'b0, 2, 8'(i)));

        // R8: small alarm level and zero
        set_alarm(7'd3);
        send(8, 8'hA1, 1'b0, 1'b0);
        send(8, 8'hA2, 1'b0, 1'b0);
        check("R8 level3 at 2", {15'b0, rx_pend}, 16'h0000);
        send(8, 8'hA3, 1'b0, 1'b0);
        check("R8 level3 at 3", {15'b0, rx_pend}, 16'h0001);
        for (int i = 0; i < 3; i++) pop_check("R4 drain2", w(1'b0, 1'b0, 1'b0, 8, 8'(8'hA1 + i)));
        check("R8 empty no pend", {15'b0, rx_pend}, 16'h0000);
        set_alarm(7'd0);
        send(11, 8'hB0, 1'b0, 1'b0);
        check("R8 level0 one char", {15'b0, rx_pend}, 16'h0001);
        pop_check("R8 level0 word", w(1'b0, 1'b0, 1'b0, 11, 8'hB0));

        // R6: fill to 64, drop one, next entry flagged
        set_alarm(7'd16);
        for (int i = 0; i < 64; i++) send(5, 8'(i), 1'b0, 1'b0);
        send(5, 8'hEE, 1'b0, 1'b0);
        pop_check("R6 head after drop", w(1'b0, 1'b0, 1'b0, 5, 8'h00));
        send(5, 8'h77, 1'b0, 1'b0);
        for (int i = 1; i < 64; i++)
            pop_check("R6 kept entries", w(1'b0, 1'b0, 1'b0, 5, 8'(i)));
        pop_check("R6 overrun after drop", w(1'b1, 1'b0, 1'b0, 5, 8'h77));
        check("R6 empty at end", rd_word, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule